// File: doc/BRIEF.md
# Vector Element Active-Mask Generator

This block sorts every element slot of a vector register group into one of four classes before an element-wise operation runs. The inputs are the start index, the vector length, the log2 group multiplier, the per-element mask bits and the mode. From the class the block derives a per-element write-enable. It also builds a pre-filled result vector in which every slot that will not be written already holds the old destination value. The arithmetic unit downstream only has to merge its results into the enabled slots.

Three modes share one classifier. Normal mode honours the mask bits. Carry mode, used by instructions whose destination is itself a mask, ignores the mask bits. Source mode is used where no destination exists, such as stores and reductions. It produces only the enable vector and drives the result vector to zero.

A separate range check flags a start index beyond the largest element index that the current element width allows. All outputs are registered and appear one clock after an input strobe.

Top module: `elem_mask_gen`

## Requirements
- R1: While `rst` is high and after its release, before any strobe, `out_valid`, `upd_en`, `elem_class`, `result` and `vstart_illegal` are all zero.
- R2: Every output is loaded on the rising edge at which `in_valid` is high, and `out_valid` is high for exactly the following cycle. When `in_valid` is low, the outputs hold their values and `out_valid` is low.
- R3: An element whose index is less than `vstart` gets class code 0 (prestart) and is not enabled. Its result lane keeps the old value.
- R4: An element not in prestart whose index is at or above `vl` gets class code 1 (tail) and is not enabled. Its result lane keeps the old value. With `vl` = 0, no element is enabled.
- R5: When `lmul_log2` (3-bit two's complement) is negative, an element that is neither prestart nor vl-tail and whose index is at or above NUM_ELEM >> (-`lmul_log2`) also gets class code 1.
- R6: In normal mode (`mode` = 0), a remaining element whose mask bit is 0 gets class code 2 (inactive), is not enabled and keeps its old value. A remaining element whose mask bit is 1 gets class code 3 (active) and is enabled, and its result lane is zero.
- R7: In carry mode (`mode` = 1), the mask bits are ignored. Every element not in prestart or tail is active.
- R8: In source mode (`mode` = 2), the classes and enables are the same as in normal mode, and the whole result vector is zero.
- R9: `tail_agn` and `mask_agn` have no effect on any output. Non-enabled lanes keep the old value under either policy.
- R10: `vstart_illegal` is 1 exactly when `vstart` > 2^(3+VLEN_LOG2-`sew_log2`) - 1, where `sew_log2` is log2 of the element width in bits.
- R11: Classes are decided in the fixed order prestart, vl-tail, fractional tail, inactive, active. An element below `vstart` is therefore prestart even when it lies at or above `vl`.
- R12: The reserved mode (`mode` = 3) behaves exactly like normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: load a new classification |
| mode | input | 2 | 0 normal, 1 carry, 2 source, 3 reserved (as normal) |
| vstart | input | CNT_W | First element index to process |
| vl | input | CNT_W | Vector length |
| lmul_log2 | input | 3 | Signed log2 of the group multiplier |
| sew_log2 | input | 3 | log2 of the element width in bits |
| tail_agn | input | 1 | Tail policy bit (no effect on outputs) |
| mask_agn | input | 1 | Inactive policy bit (no effect on outputs) |
| mask_bits | input | NUM_ELEM | Per-element mask, bit i for element i |
| old_data | input | NUM_ELEM*ELEM_W | Old destination elements, lane i at bits i*ELEM_W |
| out_valid | output | 1 | High for the cycle after a strobe |
| upd_en | output | NUM_ELEM | Per-element update enable |
| elem_class | output | 2*NUM_ELEM | Class code per element, lane i at bits 2i |
| result | output | NUM_ELEM*ELEM_W | Pre-filled result vector |
| vstart_illegal | output | 1 | Start index out of range |

## Verification
The bench sets `vstart` above `vl` to confirm that prestart wins over tail. A design with a swapped priority would report those slots as tail. It sets a fractional multiplier with `vl` equal to the full count, where a design that skips the fractional cut-off would enable the upper slots. It drives carry mode with an all-zero mask: a design that still honours the mask would show no active slots. It steps `vstart` across the exact range limit at two element widths, where an off-by-one limit flips the illegal flag. Other cases are `vl` = 0, source mode, flipped policy bits, the reserved mode, and holding while the strobe is low. These catch designs that leak old data, clear lanes or update without a strobe.

// File: rtl/emg_pkg.sv
package emg_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_CARRY  = 2'd1,
    MODE_SOURCE = 2'd2,
    MODE_RSVD   = 2'd3
  } gen_mode_e;

  typedef enum logic [1:0] {
    CLS_PRESTART = 2'd0,
    CLS_TAIL     = 2'd1,
    CLS_INACTIVE = 2'd2,
    CLS_ACTIVE   = 2'd3
  } elem_cls_e;

endpackage

// File: rtl/elem_classify.sv
module elem_classify
  import emg_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int CNT_W = 10
) (
  input  logic [CNT_W-1:0] vstart,
  input  logic [CNT_W-1:0] vl,
  input  logic             frac_en,
  input  logic [CNT_W-1:0] frac_lim,
  input  logic             mask_bit,
  input  logic             ignore_mask,
  output elem_cls_e        cls
);

  localparam logic [CNT_W-1:0] IDX_V = CNT_W'(IDX);

  // fixed priority: prestart, vl tail, fractional tail, inactive, active
  always_comb begin
    if (IDX_V < vstart)                   cls = CLS_PRESTART;
    else if (IDX_V >= vl)                 cls = CLS_TAIL;
    else if (frac_en && IDX_V >= frac_lim) cls = CLS_TAIL;
    else if (!ignore_mask && !mask_bit)   cls = CLS_INACTIVE;
    else                                  cls = CLS_ACTIVE;
  end

endmodule

// File: rtl/vstart_check.sv
module vstart_check #(
  parameter int CNT_W     = 10,
  parameter int VLEN_LOG2 = 7
) (
  input  logic [CNT_W-1:0] vstart,
  input  logic [2:0]       sew_log2,
  output logic             illegal
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  int sh;

  // largest legal index is 2^(3+VLEN_LOG2-sew_log2)-1
  always_comb begin
    sh = 3 + VLEN_LOG2 - int'(sew_log2);
    if (sh < 0)            illegal = 1'b1;
    else if (sh >= CNT_W)  illegal = 1'b0;
    else                   illegal = (vstart >= (ONE << sh));
  end

endmodule

// File: rtl/lane_reg.sv
module lane_reg
  import emg_pkg::*;
#(
  parameter int ELEM_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  elem_cls_e         cls_in,
  input  logic              source_only,
  input  logic              tail_agn,
  input  logic              mask_agn,
  input  logic [ELEM_W-1:0] old_lane,
  output logic [1:0]        cls_q,
  output logic              en_q,
  output logic [ELEM_W-1:0] data_q
);

  logic [ELEM_W-1:0] fill;

  // both policies keep the old value in a non-updated lane
  always_comb begin
    unique case (cls_in)
      CLS_PRESTART: fill = old_lane;
      CLS_TAIL:     fill = tail_agn ? old_lane : old_lane;
      CLS_INACTIVE: fill = mask_agn ? old_lane : old_lane;
      default:      fill = '0;
    endcase
    if (source_only) fill = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_q  <= 2'd0;
      en_q   <= 1'b0;
      data_q <= '0;
    end else if (load) begin
      cls_q  <= cls_in;
      en_q   <= (cls_in == CLS_ACTIVE);
      data_q <= fill;
    end
  end

endmodule

// File: rtl/elem_mask_gen.sv
module elem_mask_gen
  import emg_pkg::*;
#(
  parameter int NUM_ELEM  = 16,
  parameter int ELEM_W    = 8,
  parameter int CNT_W     = 10,
  parameter int VLEN_LOG2 = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [1:0]                 mode,
  input  logic [CNT_W-1:0]           vstart,
  input  logic [CNT_W-1:0]           vl,
  input  logic [2:0]                 lmul_log2,
  input  logic [2:0]                 sew_log2,
  input  logic                       tail_agn,
  input  logic                       mask_agn,
  input  logic [NUM_ELEM-1:0]        mask_bits,
  input  logic [NUM_ELEM*ELEM_W-1:0] old_data,
  output logic                       out_valid,
  output logic [NUM_ELEM-1:0]        upd_en,
  output logic [2*NUM_ELEM-1:0]      elem_class,
  output logic [NUM_ELEM*ELEM_W-1:0] result,
  output logic                       vstart_illegal
);

  localparam logic [CNT_W-1:0] ELEMS_V = CNT_W'(NUM_ELEM);

  gen_mode_e        mode_e;
  logic             ignore_mask;
  logic             source_only;
  logic             frac_en;
  logic [2:0]       neg_pow;
  logic [CNT_W-1:0] frac_lim;
  logic             illegal_c;

  assign mode_e      = gen_mode_e'(mode);
  assign ignore_mask = (mode_e == MODE_CARRY);
  assign source_only = (mode_e == MODE_SOURCE);
  assign frac_en     = lmul_log2[2];
  assign neg_pow     = (~lmul_log2) + 3'd1;
  assign frac_lim    = ELEMS_V >> neg_pow;

  vstart_check #(
    .CNT_W     (CNT_W),
    .VLEN_LOG2 (VLEN_LOG2)
  ) u_vchk (
    .vstart   (vstart),
    .sew_log2 (sew_log2),
    .illegal  (illegal_c)
  );

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_lane
    elem_cls_e cls_c;

    elem_classify #(
      .IDX   (i),
      .CNT_W (CNT_W)
    ) u_cls (
      .vstart      (vstart),
      .vl          (vl),
      .frac_en     (frac_en),
      .frac_lim    (frac_lim),
      .mask_bit    (mask_bits[i]),
      .ignore_mask (ignore_mask),
      .cls         (cls_c)
    );

    lane_reg #(
      .ELEM_W (ELEM_W)
    ) u_lane (
      .clk         (clk),
      .rst         (rst),
      .load        (in_valid),
      .cls_in      (cls_c),
      .source_only (source_only),
      .tail_agn    (tail_agn),
      .mask_agn    (mask_agn),
      .old_lane    (old_data[i*ELEM_W +: ELEM_W]),
      .cls_q       (elem_class[2*i +: 2]),
      .en_q        (upd_en[i]),
      .data_q      (result[i*ELEM_W +: ELEM_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      vstart_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) vstart_illegal <= illegal_c;
    end
  end

endmodule

// File: rtl/elem_mask_gen_chk.sv
module elem_mask_gen_chk #(
  parameter int NUM_ELEM = 16,
  parameter int ELEM_W   = 8,
  parameter int CNT_W    = 10
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic [1:0]                 mode,
  input logic [CNT_W-1:0]           vstart,
  input logic [CNT_W-1:0]           vl,
  input logic [2:0]                 lmul_log2,
  input logic [NUM_ELEM*ELEM_W-1:0] old_data,
  input logic                       out_valid,
  input logic [NUM_ELEM-1:0]        upd_en,
  input logic [NUM_ELEM*ELEM_W-1:0] result
);

  // R2
  strobe_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(upd_en) && $stable(result)));

  // R4
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vl == '0) |=> (upd_en == '0));

  // R8
  source_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'd2) |=> (result == '0));

  // R7
  carry_full_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'd1 && vstart == '0 && vl >= CNT_W'(NUM_ELEM) && !lmul_log2[2])
      |=> (&upd_en));

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_lane_chk
    // R3
    prestart_off_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && vstart > CNT_W'(i)) |=> !upd_en[i]);

    // R9
    keep_old_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !upd_en[i] && $past(mode) != 2'd2)
        |-> (result[i*ELEM_W +: ELEM_W] == $past(old_data[i*ELEM_W +: ELEM_W])));
  end

endmodule

bind elem_mask_gen elem_mask_gen_chk #(
  .NUM_ELEM (NUM_ELEM),
  .ELEM_W   (ELEM_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mode      (mode),
  .vstart    (vstart),
  .vl        (vl),
  .lmul_log2 (lmul_log2),
  .old_data  (old_data),
  .out_valid (out_valid),
  .upd_en    (upd_en),
  .result    (result)
);

// File: tb/elem_mask_gen_tb.sv
module elem_mask_gen_tb;

  localparam int N  = 16;
  localparam int W  = 8;
  localparam int CW = 10;
  localparam int VL2 = 7;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [1:0]     mode = 2'd0;
  logic [CW-1:0]  vstart = '0;
  logic [CW-1:0]  vl = '0;
  logic [2:0]     lmul_log2 = 3'd0;
  logic [2:0]     sew_log2 = 3'd3;
  logic           tail_agn = 1'b0;
  logic           mask_agn = 1'b0;
  logic [N-1:0]   mask_bits = '0;
  logic [N*W-1:0] old_data = '0;
  logic           out_valid;
  logic [N-1:0]   upd_en;
  logic [2*N-1:0] elem_class;
  logic [N*W-1:0] result;
  logic           vstart_illegal;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  elem_mask_gen #(.NUM_ELEM(N), .ELEM_W(W), .CNT_W(CW), .VLEN_LOG2(VL2)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .vstart(vstart),
    .vl(vl), .lmul_log2(lmul_log2), .sew_log2(sew_log2), .tail_agn(tail_agn),
    .mask_agn(mask_agn), .mask_bits(mask_bits), .old_data(old_data),
    .out_valid(out_valid), .upd_en(upd_en), .elem_class(elem_class),
    .result(result), .vstart_illegal(vstart_illegal)
  );

  task automatic check(string tag, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_cls(int i, int vst, int len, int lm, logic mb, int md);
    int lim;
    lim = (lm < 0) ? (N >> (-lm)) : N;
    if (i < vst)               return 2'd0;
    if (i >= len)              return 2'd1;
    if (i >= lim)              return 2'd1;
    if (md != 1 && !mb)        return 2'd2;
    return 2'd3;
  endfunction

  // drive one strobe, then compare all outputs against the requirement model
  task automatic run_case(string tag, int md, int vst, int len, int lm, int sew,
                          logic [N-1:0] mb, logic ta, logic ma, int seed);
    logic [2*N-1:0] e_cls;
    logic [N-1:0]   e_en;
    logic [N*W-1:0] e_res;
    logic [N*W-1:0] od;
    int             lim;
    for (int i = 0; i < N; i++) od[i*W +: W] = 8'(seed + 13*i + 1);
    @(negedge clk);
    mode = 2'(md); vstart = CW'(vst); vl = CW'(len); lmul_log2 = 3'(lm);
    sew_log2 = 3'(sew); mask_bits = mb; tail_agn = ta; mask_agn = ma;
    old_data = od; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < N; i++) begin
      e_cls[2*i +: 2] = exp_cls(i, vst, len, lm, mb[i], md);
      e_en[i] = (e_cls[2*i +: 2] == 2'd3);
      e_res[i*W +: W] = (md == 2 || e_en[i]) ? 8'd0 : od[i*W +: W];
    end
    lim = (1 << (3 + VL2 - sew)) - 1;
    check({tag, " R2 out_valid"}, (N*W)'(out_valid), (N*W)'(1));
    check({tag, " class"}, (N*W)'(elem_class), (N*W)'(e_cls));
    check({tag, " upd_en"}, (N*W)'(upd_en), (N*W)'(e_en));
    check({tag, " result"}, result, e_res);
    check({tag, " R10 illegal"}, (N*W)'(vstart_illegal), (N*W)'(vst > lim));
  endtask

  task automatic t_reset();
    check("R1 out_valid", (N*W)'(out_valid), '0);
    check("R1 upd_en", (N*W)'(upd_en), '0);
    check("R1 class", (N*W)'(elem_class), '0);
    check("R1 result", result, '0);
    check("R1 illegal", (N*W)'(vstart_illegal), '0);
  endtask

  task automatic t_normal();
    run_case("R3/R4/R6 normal", 0, 2, 12, 0, 3, 16'hA5A5, 1'b0, 1'b0, 8'h20);
    run_case("R6 normal full", 0, 0, 16, 1, 3, 16'h0FF0, 1'b0, 1'b0, 8'h41);
  endtask

  task automatic t_carry();
    run_case("R7 carry zero mask", 1, 0, 16, 0, 3, 16'h0000, 1'b0, 1'b0, 8'h55);
    run_case("R7 carry range", 1, 3, 9, 0, 4, 16'h1234, 1'b0, 1'b0, 8'h66);
  endtask

  task automatic t_frac();
    run_case("R5 frac quarter", 0, 0, 16, -2, 3, 16'hFFFF, 1'b0, 1'b0, 8'h70);
    run_case("R5 frac half vl", 1, 0, 6, -1, 3, 16'h0000, 1'b0, 1'b0, 8'h71);
    run_case("R5 frac eighth", 0, 0, 16, -3, 3, 16'hFFFF, 1'b0, 1'b0, 8'h72);
  endtask

  task automatic t_priority();
    run_case("R11 vstart over vl", 0, 10, 5, 0, 3, 16'hFFFF, 1'b0, 1'b0, 8'h80);
    run_case("R11 vstart over frac", 1, 3, 16, -3, 3, 16'hFFFF, 1'b0, 1'b0, 8'h81);
  endtask

  task automatic t_source();
    run_case("R8 source", 2, 1, 13, 0, 3, 16'h5A5A, 1'b1, 1'b1, 8'h90);
  endtask

  task automatic t_policy();
    logic [N*W-1:0] r0;
    logic [N-1:0]   e0;
    run_case("R9 policy undisturbed", 0, 2, 11, 0, 3, 16'h3C3C, 1'b0, 1'b0, 8'hA0);
    r0 = result; e0 = upd_en;
    run_case("R9 policy agnostic", 0, 2, 11, 0, 3, 16'h3C3C, 1'b1, 1'b1, 8'hA0);
    check("R9 same result", result, r0);
    check("R9 same enable", (N*W)'(upd_en), (N*W)'(e0));
  endtask

  task automatic t_illegal();
    run_case("R10 sew8 edge", 0, 127, 200, 0, 3, 16'hFFFF, 1'b0, 1'b0, 8'hB0);
    run_case("R10 sew8 over", 0, 128, 200, 0, 3, 16'hFFFF, 1'b0, 1'b0, 8'hB1);
    run_case("R10 sew64 edge", 0, 15, 16, 0, 6, 16'hFFFF, 1'b0, 1'b0, 8'hB2);
    run_case("R10 sew64 over", 0, 16, 16, 0, 6, 16'hFFFF, 1'b0, 1'b0, 8'hB3);
  endtask

  task automatic t_zero_len();
    run_case("R4 vl zero", 1, 0, 0, 0, 3, 16'hFFFF, 1'b0, 1'b0, 8'hC0);
  endtask

  task automatic t_reserved();
    run_case("R12 reserved mode", 3, 1, 14, 0, 3, 16'h9669, 1'b0, 1'b0, 8'hD0);
  endtask

  task automatic t_hold();
    logic [N*W-1:0] r0;
    logic [2*N-1:0] c0;
    run_case("R2 hold setup", 0, 0, 8, 0, 3, 16'h00F0, 1'b0, 1'b0, 8'hE0);
    r0 = result; c0 = elem_class;
    @(negedge clk);
    mode = 2'd1; vstart = '0; vl = CW'(16); mask_bits = '1; old_data = '1;
    repeat (3) @(negedge clk);
    check("R2 idle valid low", (N*W)'(out_valid), '0);
    check("R2 idle result held", result, r0);
    check("R2 idle class held", (N*W)'(elem_class), (N*W)'(c0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_carry();
    t_frac();
    t_priority();
    t_source();
    t_policy();
    t_illegal();
    t_zero_len();
    t_reserved();
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule